// File: doc/BRIEF.md
# Vector Mask Compress and Expand Unit

This unit keeps two internal vector images: a source vector and a destination vector, each of up to 64 elements of 32 bits. A command supplies a mode, an active length and a mask with one bit per element. In compress mode, every source element whose mask bit is set is copied to the next free slot of the destination, starting at slot zero, and the original order is preserved. In expand mode, the unit does the reverse: consecutive source elements starting at element zero go to the destination slots whose mask bit is set. In both modes the unit reports how many mask bits were set.

The unit handles one element per clock. The destination slot for each element comes from a running count of the set mask bits seen so far, not from a fixed mapping. Elements are written through a load port and results are read back through a combinational read port. A command starts with a single-cycle start pulse while the unit is idle. A one-cycle done pulse marks completion.

Top module: `vmask_pack_unit`

## Requirements
- R1: In compress mode (cmdExpand=0), for each index i below the active length with mask bit i set, source element i is written to destination slot j. Here j is the number of set mask bits below i. Relative order is kept.
- R2: popCount equals the number of set mask bits below the active length. It is valid in the cycle done is high, stays unchanged until the next accepted start, and is cleared to zero when a start is accepted.
- R3: In expand mode (cmdExpand=1), for the k-th set mask bit (counting from zero) at index i below the active length, destination slot i receives source element k.
- R4: Destination slots that no element is written to keep their prior contents. In expand mode these are the slots with a clear mask bit. In compress mode these are the slots at or above the final count.
- R5: Mask bits at indices at or above the active length have no effect. A cmdLen value above 64 is treated as 64.
- R6: A start accepted while idle with an active length n of 1 or more makes busy high from the next cycle for exactly n cycles. done is then high for exactly one cycle, in the cycle after the last element. With n = 0, done is high in the cycle after start, and nothing is written.
- R7: start, and any write on the load port, are ignored while busy is high.
- R8: After reset, busy, done and popCount are all zero.
- R9: While idle, ldEn writes ldData into source element ldIdx when ldDst=0, and into destination element ldIdx when ldDst=1. rdData shows destination element rdIdx in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ldEn | input | 1 | Element write strobe |
| ldDst | input | 1 | 0 selects the source image, 1 selects the destination image |
| ldIdx | input | 6 | Element index to write |
| ldData | input | 32 | Element value to write |
| rdIdx | input | 6 | Destination element index to read |
| rdData | output | 32 | Destination element value |
| start | input | 1 | Command strobe, taken only while idle |
| cmdExpand | input | 1 | 0 selects compress, 1 selects expand |
| cmdLen | input | 7 | Active vector length, clamped to 64 |
| cmdMask | input | 64 | One mask bit per element |
| busy | output | 1 | High while elements are being processed |
| done | output | 1 | One-cycle completion pulse |
| popCount | output | 7 | Number of set mask bits in the active range |

## Verification
The done pulse of one command and the acceptance of the next start can land in the same cycle. The bench provokes this by raising start in the very cycle it first sees done, with no idle cycle between them. It then runs an expand directly after a compress. The second command's latency and popCount are judged against the bench model. The final destination image is judged against the model after both commands have been applied in turn. A second overlap is also provoked: start and load writes are issued while the unit is busy. The final image and count must show that none of them took effect.

// File: rtl/vmpu_pkg.sv
package vmpu_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } vmpuState_t;

  typedef struct packed {
    logic step;    // one element is being processed this cycle
    logic take;    // that element has its mask bit set
    logic expand;  // 1: expand, 0: compress
    logic loadOk;  // load port may write this cycle
  } vmpuStrobe_t;

endpackage

// File: rtl/vmpu_ctrl.sv
module vmpu_ctrl
  import vmpu_pkg::*;
#(
  parameter int MAX_VL = 64,
  localparam int IDX_W = $clog2(MAX_VL),
  localparam int CNT_W = $clog2(MAX_VL + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              cmdExpand,
  input  logic [CNT_W-1:0]  cmdLen,
  input  logic [MAX_VL-1:0] cmdMask,
  output vmpuStrobe_t       strb,
  output logic [IDX_W-1:0]  elemIdx,
  output logic [IDX_W-1:0]  packIdx,
  output logic              busy,
  output logic              done,
  output logic [CNT_W-1:0]  popCount
);

  vmpuState_t        state;
  logic [MAX_VL-1:0] maskReg;
  logic              modeReg;
  logic [IDX_W-1:0]  lastIdx;
  logic [CNT_W-1:0]  packCnt;
  logic [CNT_W-1:0]  effLen;
  logic              isLast;

  assign effLen = (cmdLen > CNT_W'(MAX_VL)) ? CNT_W'(MAX_VL) : cmdLen;
  assign isLast = (elemIdx == lastIdx);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      maskReg <= '0;
      modeReg <= 1'b0;
      lastIdx <= '0;
      packCnt <= '0;
      elemIdx <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            modeReg <= cmdExpand;
            maskReg <= cmdMask;
            packCnt <= '0;
            elemIdx <= '0;
            lastIdx <= IDX_W'(effLen - CNT_W'(1));
            if (effLen == '0) done  <= 1'b1;
            else              state <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (maskReg[elemIdx]) packCnt <= packCnt + CNT_W'(1);
          if (isLast) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else begin
            elemIdx <= elemIdx + IDX_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy        = (state == ST_RUN);
  assign strb.step   = busy;
  assign strb.take   = busy && maskReg[elemIdx];
  assign strb.expand = modeReg;
  assign strb.loadOk = !busy;
  assign packIdx     = packCnt[IDX_W-1:0];
  assign popCount    = packCnt;

  // R6: completing the last element yields done and drops busy
  assert_last_done_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && isLast) |=> (done && !busy));

  // R6: done is never raised while elements are still in flight
  assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R7: a mid-run start must not disturb the latched command
  assert_cmd_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !isLast) |=> (busy && $stable(maskReg) && $stable(modeReg) && $stable(lastIdx)));

  // R2: running count can never exceed the number of elements seen
  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (packCnt <= CNT_W'(elemIdx)));

endmodule

// File: rtl/vmpu_datapath.sv
module vmpu_datapath
  import vmpu_pkg::*;
#(
  parameter int MAX_VL = 64,
  parameter int ELEM_W = 32,
  localparam int IDX_W = $clog2(MAX_VL)
) (
  input  logic              clk,
  input  logic              rstN,
  input  vmpuStrobe_t       strb,
  input  logic [IDX_W-1:0]  elemIdx,
  input  logic [IDX_W-1:0]  packIdx,
  input  logic              ldEn,
  input  logic              ldDst,
  input  logic [IDX_W-1:0]  ldIdx,
  input  logic [ELEM_W-1:0] ldData,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [ELEM_W-1:0] rdData
);

  logic [ELEM_W-1:0] srcMem [MAX_VL];
  logic [ELEM_W-1:0] dstMem [MAX_VL];

  always_ff @(posedge clk) begin
    if (strb.loadOk && ldEn && !ldDst) srcMem[ldIdx] <= ldData;
  end

  always_ff @(posedge clk) begin
    if (strb.loadOk && ldEn && ldDst) begin
      dstMem[ldIdx] <= ldData;
    end else if (strb.take) begin
      if (strb.expand) dstMem[elemIdx] <= srcMem[packIdx];
      else             dstMem[packIdx] <= srcMem[elemIdx];
    end
  end

  assign rdData = dstMem[rdIdx];

  // R1: the packed slot never runs ahead of the element being scanned
  assert_pack_index_R1: assert property (@(posedge clk) disable iff (!rstN)
    strb.step |-> (packIdx <= elemIdx));

  // R7: a load never coincides with an element write
  assert_load_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.take |-> !strb.loadOk);

endmodule

// File: rtl/vmask_pack_unit.sv
module vmask_pack_unit
  import vmpu_pkg::*;
#(
  parameter int MAX_VL = 64,
  parameter int ELEM_W = 32,
  localparam int IDX_W = $clog2(MAX_VL),
  localparam int CNT_W = $clog2(MAX_VL + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ldEn,
  input  logic              ldDst,
  input  logic [IDX_W-1:0]  ldIdx,
  input  logic [ELEM_W-1:0] ldData,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [ELEM_W-1:0] rdData,
  input  logic              start,
  input  logic              cmdExpand,
  input  logic [CNT_W-1:0]  cmdLen,
  input  logic [MAX_VL-1:0] cmdMask,
  output logic              busy,
  output logic              done,
  output logic [CNT_W-1:0]  popCount
);

  vmpuStrobe_t      strb;
  logic [IDX_W-1:0] elemIdx;
  logic [IDX_W-1:0] packIdx;

  vmpu_ctrl #(.MAX_VL(MAX_VL)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .cmdExpand(cmdExpand),
    .cmdLen(cmdLen), .cmdMask(cmdMask), .strb(strb), .elemIdx(elemIdx),
    .packIdx(packIdx), .busy(busy), .done(done), .popCount(popCount)
  );

  vmpu_datapath #(.MAX_VL(MAX_VL), .ELEM_W(ELEM_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .elemIdx(elemIdx), .packIdx(packIdx),
    .ldEn(ldEn), .ldDst(ldDst), .ldIdx(ldIdx), .ldData(ldData),
    .rdIdx(rdIdx), .rdData(rdData)
  );

endmodule

// File: tb/tb_vmask_pack_unit.sv
module tb_vmask_pack_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ldEn = 1'b0, ldDst = 1'b0;
  logic [5:0]  ldIdx = '0, rdIdx = '0;
  logic [31:0] ldData = '0, rdData;
  logic        start = 1'b0, cmdExpand = 1'b0;
  logic [6:0]  cmdLen = '0;
  logic [63:0] cmdMask = '0;
  logic        busy, done;
  logic [6:0]  popCount;

  int total = 0, bad = 0;
  bit finished = 1'b0;
  logic [31:0] mSrc [64];
  logic [31:0] mDst [64];
  int expPop = 0;

  always #5 clk = ~clk;

  vmask_pack_unit dut (
    .clk(clk), .rstN(rstN), .ldEn(ldEn), .ldDst(ldDst), .ldIdx(ldIdx),
    .ldData(ldData), .rdIdx(rdIdx), .rdData(rdData), .start(start),
    .cmdExpand(cmdExpand), .cmdLen(cmdLen), .cmdMask(cmdMask),
    .busy(busy), .done(done), .popCount(popCount)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic applyModel(input bit md, input int vl, input logic [63:0] m);
    logic [31:0] nd [64];
    int eff = (vl > 64) ? 64 : vl;
    int k = 0;
    for (int i = 0; i < 64; i++) nd[i] = mDst[i];
    for (int i = 0; i < eff; i++) begin
      if (m[i]) begin
        if (md) nd[i] = mSrc[k];
        else    nd[k] = mSrc[i];
        k++;
      end
    end
    for (int i = 0; i < 64; i++) mDst[i] = nd[i];
    expPop = k;
  endtask

  task automatic loadAll();
    for (int i = 0; i < 64; i++) begin
      ldEn = 1'b1; ldDst = 1'b0; ldIdx = 6'(i); ldData = $urandom;
      mSrc[i] = ldData;
      @(negedge clk);
    end
    for (int i = 0; i < 64; i++) begin
      ldEn = 1'b1; ldDst = 1'b1; ldIdx = 6'(i); ldData = $urandom;
      mDst[i] = ldData;
      @(negedge clk);
    end
    ldEn = 1'b0;
  endtask

  task automatic checkDst(input string req);
    int miss = 0, firstI = -1;
    logic [31:0] a = '0, e = '0;
    for (int i = 0; i < 64; i++) begin
      rdIdx = 6'(i);
      #0.1;
      if (rdData !== mDst[i]) begin
        if (miss == 0) begin firstI = i; a = rdData; e = mDst[i]; end
        miss++;
      end
    end
    chk(miss == 0, req, $sformatf("dst image slot %0d", firstI), a, e);
  endtask

  task automatic doOp(input bit md, input int vl, input logic [63:0] m,
                      input bit chain, input bit poke);
    int eff = (vl > 64) ? 64 : vl;
    int cyc;
    cmdExpand = md; cmdLen = 7'(vl); cmdMask = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0; cyc = 1;
    if (eff > 0) chk(busy == 1'b1, "R6", "busy after start", busy, 1);
    if (poke && eff >= 4) begin
      start = 1'b1; cmdExpand = ~md; cmdMask = ~m; cmdLen = 7'd64;
      ldEn = 1'b1; ldDst = 1'b0; ldIdx = 6'd0; ldData = 32'hDEAD_BEEF;
    end
    while (!done && cyc < 300) begin
      @(negedge clk);
      cyc++;
      if (poke && cyc == 2) begin ldDst = 1'b1; ldIdx = 6'd1; end
      if (poke && cyc == 3) begin start = 1'b0; ldEn = 1'b0; end
    end
    chk(done == 1'b1, "R6", "done seen", done, 1);
    chk(cyc == eff + 1, "R6", "cycles to done", cyc, eff + 1);
    applyModel(md, vl, m);
    chk(popCount == 7'(expPop), "R2", "popCount", popCount, expPop);
    if (!chain) begin
      @(negedge clk);
      chk(done == 1'b0, "R6", "done width", done, 0);
      chk(popCount == 7'(expPop), "R2", "popCount held", popCount, expPop);
    end
  endtask

  initial begin
    #1500000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired act=1 exp=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R8", "busy after reset", busy, 0);
    chk(done == 1'b0, "R8", "done after reset", done, 0);
    chk(popCount == 7'd0, "R8", "popCount after reset", popCount, 0);

    // R9 load then read back; R1 full-length compress with all mask bits set
    loadAll();
    checkDst("R9");
    doOp(1'b0, 64, {64{1'b1}}, 1'b0, 1'b0);
    checkDst("R1");

    // R1/R4/R5: compress with mask bits set above the active length
    loadAll();
    doOp(1'b0, 20, 64'hFFFF_F000_0005_A3C9, 1'b0, 1'b0);
    checkDst("R4");

    // R3/R4: expand
    loadAll();
    doOp(1'b1, 37, 64'hF0F0_0000_1234_5678, 1'b0, 1'b0);
    checkDst("R3");

    // R5: length above 64 is clamped
    loadAll();
    doOp(1'b1, 100, 64'h8000_0000_0000_0001, 1'b0, 1'b0);
    checkDst("R5");

    // R6: zero length writes nothing
    loadAll();
    doOp(1'b0, 0, {64{1'b1}}, 1'b0, 1'b0);
    checkDst("R6");

    // single element, then an empty mask
    doOp(1'b0, 1, 64'h1, 1'b0, 1'b0);
    checkDst("R1");
    doOp(1'b1, 64, 64'h0, 1'b0, 1'b0);
    checkDst("R4");

    // R7: start and loads during a run are ignored
    loadAll();
    doOp(1'b1, 30, 64'h0000_0000_2AF0_19C3, 1'b0, 1'b1);
    checkDst("R7");

    // back-to-back: next start in the same cycle as done
    loadAll();
    doOp(1'b0, 40, 64'h0000_00A5_5A3C_C3F1, 1'b1, 1'b0);
    doOp(1'b1, 40, 64'h0000_0077_1E2D_8B40, 1'b0, 1'b0);
    checkDst("R6");

    // random commands
    for (int t = 0; t < 20; t++) begin
      logic [63:0] rm;
      bit md;
      int vl;
      rm = {$urandom, $urandom};
      md = 1'($urandom);
      vl = int'($urandom % 81);
      loadAll();
      doOp(md, vl, rm, 1'b0, (t % 5) == 0);
      checkDst(md ? "R3" : "R1");
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule